// File: doc/BRIEF.md
# Element-Width Saturating Add/Subtract Unit

This unit adds or subtracts one pair of integer elements under an element-width override. A two-bit width code selects the element size. It can select the native 64-bit size, a byte, a halfword or a word. Separate codes are given for the source and for the destination. Each operand is first extended from the source width, as signed or unsigned according to the N input. The sum or difference is then formed exactly at a width large enough for either element size. After that, the result is reduced to the destination width.

When saturation is enabled, out-of-range results are clamped to the destination range. The range is unsigned when N=0 and signed when N=1. The fact that clamping took place is reported in the overflow bit of a per-element condition field. Nothing is accumulated across elements. The same field also carries less-than, greater-than and equal-to-zero flags for the result. A request that asks for saturation together with a carry-producing operation is rejected and marked illegal, because both would claim the same condition bit. All outputs are registered with one cycle of latency.

Top module: `elem_sat_alu`

## Requirements
- R1: Width code 2'b00 selects 64 bits. 2'b01 selects 8 bits, 2'b10 selects 16 bits and 2'b11 selects 32 bits. The codes apply both to the source (`src_wcode`) and to the destination (`dst_wcode`).
- R2: When `sat_en`=1 and `sat_signed`=0, the result is clamped to the range 0 to 2^w-1, where w is the destination width.
- R3: When `sat_en`=1 and `sat_signed`=1, the result is clamped to the range -2^(w-1) to 2^(w-1)-1 and sign-extended to 64 bits.
- R4: `cr_ov` is 1 exactly when clamping changed the value. It is always 0 when `sat_en`=0.
- R5: When `sat_en`=0, the exact result is truncated to the destination width. It is then zero-extended (`sat_signed`=0) or sign-extended (`sat_signed`=1) to 64 bits.
- R6: When `sat_en`=1 and `carry_req`=1 together, the request is illegal: `illegal`=1, `result`=0, and `cr_ov`, `cr_lt`, `cr_gt` and `cr_eq` are all 0.
- R7: Operands are extended from the source width before the operation: sign-extended if `sat_signed`=1, zero-extended otherwise. `op_sub`=1 computes a-b and `op_sub`=0 computes a+b.
- R8: Outputs appear on the clock edge after an input with `in_valid`=1. `out_valid` follows `in_valid` with one cycle of delay.
- R9: For a legal request, exactly one of `cr_lt`, `cr_gt` and `cr_eq` is 1. `cr_eq` means the result is zero. `cr_lt` means `sat_signed`=1 and bit 63 of the result is set.
- R10: After reset, `out_valid`, `result`, `illegal` and all condition flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| op_a | input | 64 | First operand |
| op_b | input | 64 | Second operand |
| op_sub | input | 1 | 1: a-b, 0: a+b |
| src_wcode | input | 2 | Source element width code |
| dst_wcode | input | 2 | Destination element width code |
| sat_en | input | 1 | Enable saturation |
| sat_signed | input | 1 | N: signed (1) or unsigned (0) handling |
| carry_req | input | 1 | Operation would produce a carry |
| out_valid | output | 1 | Result valid |
| result | output | 64 | Clamped or truncated result |
| cr_ov | output | 1 | Saturation occurred |
| cr_lt | output | 1 | Result negative |
| cr_gt | output | 1 | Result positive |
| cr_eq | output | 1 | Result zero |
| illegal | output | 1 | Saturation combined with carry |

## Verification
Clamping and illegal-request detection can both apply to the same request. This happens when an overflowing sum is issued with both `sat_en` and `carry_req` set. The bench sends such requests in directed form and also mixes them into random traffic. For each one it expects the illegal outcome to take priority: a zero result and a cleared overflow bit. A second overlap is between clamping and the condition flags, since a clamped value must still produce exactly one of lt, gt or eq. The bench checks this on every signed and unsigned saturation case.

// File: rtl/elem_sat_alu.sv
module elem_sat_alu #(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [XLEN-1:0] op_a,
  input  logic [XLEN-1:0] op_b,
  input  logic            op_sub,
  input  logic [1:0]      src_wcode,
  input  logic [1:0]      dst_wcode,
  input  logic            sat_en,
  input  logic            sat_signed,
  input  logic            carry_req,
  output logic            out_valid,
  output logic [XLEN-1:0] result,
  output logic            cr_ov,
  output logic            cr_lt,
  output logic            cr_gt,
  output logic            cr_eq,
  output logic            illegal
);
  localparam int EW = XLEN + 2;

  function automatic int wbits(input logic [1:0] c);
    case (c)
      2'b01:   return 8;
      2'b10:   return 16;
      2'b11:   return 32;
      default: return XLEN;
    endcase
  endfunction

  function automatic logic signed [EW-1:0] widen(input logic [XLEN-1:0] v,
                                                 input logic [1:0] c,
                                                 input logic sgn);
    logic [EW-1:0] r;
    int w;
    w = wbits(c);
    for (int i = 0; i < EW; i++)
      r[i] = (i < w) ? v[i] : (sgn & v[w-1]);
    return signed'(r);
  endfunction

  logic signed [EW-1:0] one, sa, sb, raw, hi, lo, clamped, picked, fin;
  logic over, under, bad, zero, neg;
  int dw;

  assign one = EW'(1);
  assign dw  = wbits(dst_wcode);
  assign sa  = widen(op_a, src_wcode, sat_signed);
  assign sb  = widen(op_b, src_wcode, sat_signed);
  assign raw = op_sub ? (sa - sb) : (sa + sb);
  assign hi  = sat_signed ? ((one <<< (dw - 1)) - one) : ((one <<< dw) - one);
  assign lo  = sat_signed ? -(one <<< (dw - 1)) : '0;

  assign over    = raw > hi;
  assign under   = raw < lo;
  assign clamped = over ? hi : (under ? lo : raw);
  assign picked  = sat_en ? clamped : raw;
  assign fin     = widen(picked[XLEN-1:0], dst_wcode, sat_signed);
  assign bad     = sat_en & carry_req;
  assign zero    = (fin[XLEN-1:0] == '0);
  assign neg     = sat_signed & fin[XLEN-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      cr_ov     <= 1'b0;
      cr_lt     <= 1'b0;
      cr_gt     <= 1'b0;
      cr_eq     <= 1'b0;
      illegal   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        illegal <= bad;
        result  <= bad ? '0 : fin[XLEN-1:0];
        cr_ov   <= ~bad & sat_en & (over | under);
        cr_eq   <= ~bad & zero;
        cr_lt   <= ~bad & neg;
        cr_gt   <= ~bad & ~zero & ~neg;
      end
    end
  end
endmodule

module elem_sat_alu_chk #(
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic [1:0]      dst_wcode,
  input logic            sat_en,
  input logic            sat_signed,
  input logic            carry_req,
  input logic            out_valid,
  input logic [XLEN-1:0] result,
  input logic            cr_ov,
  input logic            cr_lt,
  input logic            cr_gt,
  input logic            cr_eq,
  input logic            illegal
);
  a_r8_valid_rise: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r8_valid_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  a_r4_no_ov_without_sat: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !sat_en) |=> !cr_ov);
  a_r6_illegal_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && sat_en && carry_req) |=> (illegal && result == '0 && !cr_ov));
  a_r2_byte_unsigned_range: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && sat_en && !sat_signed && dst_wcode == 2'b01) |=> (result[XLEN-1:8] == '0));
  a_r9_one_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !illegal) |-> ($countones({cr_lt, cr_gt, cr_eq}) == 1));
endmodule

bind elem_sat_alu elem_sat_alu_chk #(.XLEN(XLEN)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .dst_wcode(dst_wcode),
  .sat_en(sat_en), .sat_signed(sat_signed), .carry_req(carry_req),
  .out_valid(out_valid), .result(result), .cr_ov(cr_ov), .cr_lt(cr_lt),
  .cr_gt(cr_gt), .cr_eq(cr_eq), .illegal(illegal)
);

// File: tb/elem_sat_alu_tb_top.sv
module elem_sat_alu_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [63:0] op_a = '0, op_b = '0;
  logic op_sub = 1'b0, sat_en = 1'b0, sat_signed = 1'b0, carry_req = 1'b0;
  logic [1:0] src_wcode = '0, dst_wcode = '0;
  logic out_valid, cr_ov, cr_lt, cr_gt, cr_eq, illegal;
  logic [63:0] result;

  int n_tests = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  elem_sat_alu dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .op_sub(op_sub), .src_wcode(src_wcode), .dst_wcode(dst_wcode),
    .sat_en(sat_en), .sat_signed(sat_signed), .carry_req(carry_req),
    .out_valid(out_valid), .result(result), .cr_ov(cr_ov), .cr_lt(cr_lt),
    .cr_gt(cr_gt), .cr_eq(cr_eq), .illegal(illegal)
  );

  function automatic int bw(input logic [1:0] c);
    if (c == 2'b01) return 8;
    if (c == 2'b10) return 16;
    if (c == 2'b11) return 32;
    return 64;
  endfunction

  function automatic logic signed [67:0] mval(input logic [63:0] a, input int w, input logic s);
    logic [63:0] low;
    logic signed [67:0] r;
    low = (w == 64) ? a : (a & ((64'd1 << w) - 64'd1));
    r = {4'b0, low};
    if (s && a[w-1]) r = r - (68'sd1 <<< w);
    return r;
  endfunction

  task automatic check(input string tag, input string what, input logic [63:0] got, input logic [63:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  task automatic run_one(input string tag, input logic [63:0] a, input logic [63:0] b,
                         input logic sub, input logic [1:0] sc, input logic [1:0] dc,
                         input logic se, input logic sg, input logic cq);
    logic signed [67:0] x, hi, lo, v;
    logic [63:0] er;
    logic eov, elt, egt, eeq, eill;
    int ws, wd;
    @(negedge clk);
    in_valid = 1'b1; op_a = a; op_b = b; op_sub = sub; src_wcode = sc;
    dst_wcode = dc; sat_en = se; sat_signed = sg; carry_req = cq;
    ws = bw(sc); wd = bw(dc);
    x = sub ? (mval(a, ws, sg) - mval(b, ws, sg)) : (mval(a, ws, sg) + mval(b, ws, sg));
    if (sg) begin
      hi = (68'sd1 <<< (wd - 1)) - 68'sd1;
      lo = -(68'sd1 <<< (wd - 1));
    end else begin
      hi = (68'sd1 <<< wd) - 68'sd1;
      lo = 68'sd0;
    end
    v = x; eov = 1'b0;
    if (se && x > hi) begin v = hi; eov = 1'b1; end
    if (se && x < lo) begin v = lo; eov = 1'b1; end
    er = mval(v[63:0], wd, sg) [63:0];
    eill = se & cq;
    eeq = (er == 64'd0);
    elt = sg & er[63];
    egt = !eeq && !elt;
    if (eill) begin er = '0; eov = 0; elt = 0; egt = 0; eeq = 0; end
    @(negedge clk);
    check("R8", "out_valid", {63'd0, out_valid}, 64'd1);
    check(tag, "result", result, er);
    check("R4", "cr_ov", {63'd0, cr_ov}, {63'd0, eov});
    check("R9", "cr_lt", {63'd0, cr_lt}, {63'd0, elt});
    check("R9", "cr_gt", {63'd0, cr_gt}, {63'd0, egt});
    check("R9", "cr_eq", {63'd0, cr_eq}, {63'd0, eeq});
    check("R6", "illegal", {63'd0, illegal}, {63'd0, eill});
  endtask

  function automatic logic [63:0] pick_op(input int sel);
    case (sel % 5)
      0: return {$urandom, $urandom};
      1: return 64'($urandom % 300);
      2: return 64'h7F + 64'($urandom % 4) - 64'd2;
      3: return 64'hFFFF_FFFF_FFFF_FF80 + 64'($urandom % 256);
      default: return 64'h7FFF_FFFF + 64'($urandom % 3);
    endcase
  endfunction

  initial begin
    #4000000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R10", "reset out_valid", {63'd0, out_valid}, 64'd0);
    check("R10", "reset result", result, 64'd0);
    check("R10", "reset flags", {59'd0, cr_ov, cr_lt, cr_gt, cr_eq, illegal}, 64'd0);
    rst_n = 1'b1;

    run_one("R2", 64'd200, 64'd100, 0, 2'b01, 2'b01, 1, 0, 0);
    run_one("R2", 64'd5, 64'd10, 1, 2'b10, 2'b10, 1, 0, 0);
    run_one("R3", 64'd100, 64'd100, 0, 2'b01, 2'b01, 1, 1, 0);
    run_one("R3", 64'hFFFF_FFFF_FFFF_FF9C, 64'd100, 1, 2'b01, 2'b01, 1, 1, 0);
    run_one("R3", 64'h7FFF_FFFF, 64'd1, 0, 2'b11, 2'b11, 1, 1, 0);
    run_one("R5", 64'd200, 64'd100, 0, 2'b01, 2'b01, 0, 0, 0);
    run_one("R5", 64'd100, 64'd100, 0, 2'b01, 2'b01, 0, 1, 0);
    run_one("R7", 64'hFF, 64'd1, 0, 2'b01, 2'b10, 1, 1, 0);
    run_one("R7", 64'hFF, 64'd1, 0, 2'b01, 2'b10, 1, 0, 0);
    run_one("R1", 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 0, 2'b00, 2'b00, 1, 0, 0);
    run_one("R1", 64'h7FFF_FFFF_FFFF_FFFF, 64'd1, 0, 2'b00, 2'b00, 1, 1, 0);
    run_one("R1", 64'h1_2345, 64'h1, 0, 2'b00, 2'b10, 1, 0, 0);
    run_one("R6", 64'd200, 64'd100, 0, 2'b01, 2'b01, 1, 0, 1);
    run_one("R6", 64'd3, 64'd4, 0, 2'b01, 2'b01, 0, 0, 1);

    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    check("R8", "out_valid drop", {63'd0, out_valid}, 64'd0);

    for (int k = 0; k < 400; k++) begin
      run_one("R5", pick_op($urandom), pick_op($urandom), 1'($urandom),
              2'($urandom), 2'($urandom), 1'($urandom), 1'($urandom),
              ($urandom % 8) == 0);
    end

    @(negedge clk);
    in_valid = 1'b0;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule